// File: doc/BRIEF.md
# Frequency-Counted Cache Replacement Unit

This unit is the tag and replacement half of a small fully associative cache. Each cycle it may receive one lookup, which is a tag qualified by a valid strobe. It answers one cycle later with hit or miss and the way that was hit or filled. On a miss into a full store it also gives the tag it pushed out. No data array is kept. The surrounding cache uses the reported way and the evicted tag to move its own data.

Each way holds a tag, a valid flag, a saturating hit counter and a recency rank. The victim is chosen by frequency first: the way with the fewest recorded uses goes out, even if it was touched more recently than the others. Recency matters only when counts are equal; the least recently used of the tied ways is then evicted. An evicted tag loses all history. This keeps frequently used lines resident when newer lines alternate, and it shows the usual all-miss behaviour under a cyclic sweep one tag wider than the store.

Top module: `freq_repl_unit`

## Requirements
- R1: Synchronous active-high reset empties every way and clears rsp_valid, rsp_hit and evict_valid; the first lookup after reset misses.
- R2: On a miss while some way is invalid, the lowest-numbered invalid way is filled and evict_valid stays 0.
- R3: A filled way starts with count 1. Each hit adds 1, and the count saturates at 2^CNT_W-1 (15 by default) instead of wrapping.
- R4: A lookup whose tag matches a valid way reports rsp_hit=1 and that way's index on rsp_way, with evict_valid=0.
- R5: On a miss with all ways valid, the way with the smallest count is replaced, even when it is the most recently used.
- R6: When several ways share the smallest count, the least recently used of them is replaced.
- R7: A replacement reports evict_valid=1, the old tag on evict_tag and the replaced way on rsp_way. A returning evicted tag restarts at count 1.
- R8: Recency ranks stay a permutation of 0..NUM_WAYS-1. Each lookup makes the touched way most recent, and only the ways that were more recent than it age by one.
- R9: rsp_valid and the other outputs are registered and appear one cycle after the request. A cycle with req_valid=0 gives rsp_valid=0 and changes no state.
- R10: With three ways, the sweep 1,2,3,4,1,2,3 misses on every access. The sequence 1,1,2,2,3,4,3,4 keeps 1 and 2 resident while 3 and 4 keep evicting each other through way 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup strobe |
| req_tag | input | TAG_W | Tag looked up |
| rsp_valid | output | 1 | Response present (one cycle after the request) |
| rsp_hit | output | 1 | 1 = hit, 0 = miss |
| rsp_way | output | WAY_W | Way hit or filled |
| evict_valid | output | 1 | A valid tag was replaced |
| evict_tag | output | TAG_W | Tag that was replaced |

## Verification
The hardest case to reach is counter saturation, because a count is only visible through which way loses a later replacement. The stimulus hits one tag fifteen times so that a wrapping counter would sit at zero. It then fills two other ways, raises each to count two and forces a miss. Evicting the older of those two shows saturation, while evicting the heavily used tag would expose wrap-around. A separate sequence hits the ways in a non-index order before a tied miss, so that recency-based tie-breaking can be told apart from lowest-index selection.

// File: rtl/freq_repl_pkg.sv
package freq_repl_pkg;

    localparam int DEF_WAYS  = 3;
    localparam int DEF_TAG_W = 8;
    localparam int DEF_CNT_W = 4;

    typedef enum logic [1:0] {
        ACC_IDLE    = 2'd0,
        ACC_HIT     = 2'd1,
        ACC_FILL    = 2'd2,
        ACC_REPLACE = 2'd3
    } acc_kind_e;

    // Candidate beats the current best victim: lower count, or equal count and older.
    function automatic logic beats_victim(input int cnt_cand, input int rank_cand,
                                          input int cnt_best, input int rank_best);
        return (cnt_cand < cnt_best) ||
               ((cnt_cand == cnt_best) && (rank_cand > rank_best));
    endfunction

endpackage

// File: rtl/frq_tag_match.sv
module frq_tag_match #(
    parameter int NUM_WAYS = 3,
    parameter int TAG_W    = 8,
    parameter int WAY_W    = 2
) (
    input  logic [NUM_WAYS-1:0]       vld_vec,
    input  logic [NUM_WAYS*TAG_W-1:0] tag_flat,
    input  logic [TAG_W-1:0]          req_tag,
    output logic                      hit,
    output logic [WAY_W-1:0]          hit_way
);
    logic [NUM_WAYS-1:0] match;

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_cmp
        assign match[w] = vld_vec[w] && (tag_flat[w*TAG_W +: TAG_W] == req_tag);
    end

    always_comb begin
        hit     = 1'b0;
        hit_way = '0;
        for (int w = NUM_WAYS - 1; w >= 0; w--) begin
            if (match[w]) begin
                hit     = 1'b1;
                hit_way = WAY_W'(w);
            end
        end
    end
endmodule

// File: rtl/frq_victim_pick.sv
module frq_victim_pick
    import freq_repl_pkg::*;
#(
    parameter int NUM_WAYS = 3,
    parameter int CNT_W    = 4,
    parameter int RANK_W   = 2,
    parameter int WAY_W    = 2
) (
    input  logic [NUM_WAYS-1:0]        vld_vec,
    input  logic [NUM_WAYS*CNT_W-1:0]  cnt_flat,
    input  logic [NUM_WAYS*RANK_W-1:0] rank_flat,
    output logic                       full,
    output logic [WAY_W-1:0]           free_way,
    output logic [WAY_W-1:0]           victim_way
);
    always_comb begin
        free_way = '0;
        for (int w = NUM_WAYS - 1; w >= 0; w--) begin
            if (!vld_vec[w]) free_way = WAY_W'(w);
        end
    end

    assign full = &vld_vec;

    always_comb begin
        int best;
        best = 0;
        for (int w = 1; w < NUM_WAYS; w++) begin
            if (beats_victim(int'(cnt_flat[w*CNT_W +: CNT_W]),
                             int'(rank_flat[w*RANK_W +: RANK_W]),
                             int'(cnt_flat[best*CNT_W +: CNT_W]),
                             int'(rank_flat[best*RANK_W +: RANK_W])))
                best = w;
        end
        victim_way = WAY_W'(best);
    end
endmodule

// File: rtl/frq_rank_ager.sv
module frq_rank_ager #(
    parameter int NUM_WAYS = 3,
    parameter int RANK_W   = 2,
    parameter int WAY_W    = 2
) (
    input  logic [NUM_WAYS*RANK_W-1:0] rank_flat,
    input  logic [WAY_W-1:0]           touch_way,
    output logic [NUM_WAYS*RANK_W-1:0] rank_next
);
    logic [RANK_W-1:0] touch_rank;

    assign touch_rank = rank_flat[touch_way*RANK_W +: RANK_W];

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_age
        logic [RANK_W-1:0] cur;
        assign cur = rank_flat[w*RANK_W +: RANK_W];
        always_comb begin
            if (touch_way == WAY_W'(w))
                rank_next[w*RANK_W +: RANK_W] = '0;
            else if (cur < touch_rank)
                rank_next[w*RANK_W +: RANK_W] = cur + 1'b1;
            else
                rank_next[w*RANK_W +: RANK_W] = cur;
        end
    end
endmodule

// File: rtl/freq_repl_unit.sv
module freq_repl_unit
    import freq_repl_pkg::*;
#(
    parameter int NUM_WAYS = DEF_WAYS,
    parameter int TAG_W    = DEF_TAG_W,
    parameter int CNT_W    = DEF_CNT_W,
    localparam int WAY_W   = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [TAG_W-1:0] req_tag,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic [WAY_W-1:0] rsp_way,
    output logic             evict_valid,
    output logic [TAG_W-1:0] evict_tag
);
    localparam int RANK_W = WAY_W;
    localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(1);

    logic [NUM_WAYS-1:0]        vld_vec;
    logic [NUM_WAYS*TAG_W-1:0]  tag_flat;
    logic [NUM_WAYS*CNT_W-1:0]  cnt_flat;
    logic [NUM_WAYS*RANK_W-1:0] rank_flat;
    logic [NUM_WAYS*RANK_W-1:0] rank_next;

    logic             hit;
    logic [WAY_W-1:0] hit_way;
    logic             full;
    logic [WAY_W-1:0] free_way;
    logic [WAY_W-1:0] victim_way;
    acc_kind_e        kind;
    logic [WAY_W-1:0] tgt_way;

    frq_tag_match #(.NUM_WAYS(NUM_WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_match (
        .vld_vec (vld_vec),
        .tag_flat(tag_flat),
        .req_tag (req_tag),
        .hit     (hit),
        .hit_way (hit_way)
    );

    frq_victim_pick #(.NUM_WAYS(NUM_WAYS), .CNT_W(CNT_W), .RANK_W(RANK_W), .WAY_W(WAY_W)) u_pick (
        .vld_vec   (vld_vec),
        .cnt_flat  (cnt_flat),
        .rank_flat (rank_flat),
        .full      (full),
        .free_way  (free_way),
        .victim_way(victim_way)
    );

    frq_rank_ager #(.NUM_WAYS(NUM_WAYS), .RANK_W(RANK_W), .WAY_W(WAY_W)) u_age (
        .rank_flat(rank_flat),
        .touch_way(tgt_way),
        .rank_next(rank_next)
    );

    always_comb begin
        kind    = ACC_IDLE;
        tgt_way = '0;
        if (req_valid) begin
            if (hit) begin
                kind    = ACC_HIT;
                tgt_way = hit_way;
            end else if (!full) begin
                kind    = ACC_FILL;
                tgt_way = free_way;
            end else begin
                kind    = ACC_REPLACE;
                tgt_way = victim_way;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_vec     <= '0;
            tag_flat    <= '0;
            cnt_flat    <= '0;
            for (int w = 0; w < NUM_WAYS; w++)
                rank_flat[w*RANK_W +: RANK_W] <= RANK_W'(w);
            rsp_valid   <= 1'b0;
            rsp_hit     <= 1'b0;
            rsp_way     <= '0;
            evict_valid <= 1'b0;
            evict_tag   <= '0;
        end else begin
            rsp_valid   <= req_valid;
            rsp_hit     <= (kind == ACC_HIT);
            rsp_way     <= tgt_way;
            evict_valid <= (kind == ACC_REPLACE);
            evict_tag   <= (kind == ACC_REPLACE) ? tag_flat[victim_way*TAG_W +: TAG_W] : '0;
            if (kind != ACC_IDLE) begin
                rank_flat <= rank_next;
                for (int w = 0; w < NUM_WAYS; w++) begin
                    if (tgt_way == WAY_W'(w)) begin
                        if (kind == ACC_HIT) begin
                            if (cnt_flat[w*CNT_W +: CNT_W] != CNT_MAX)
                                cnt_flat[w*CNT_W +: CNT_W] <= cnt_flat[w*CNT_W +: CNT_W] + 1'b1;
                        end else begin
                            vld_vec[w]                 <= 1'b1;
                            tag_flat[w*TAG_W +: TAG_W] <= req_tag;
                            cnt_flat[w*CNT_W +: CNT_W] <= CNT_INIT;
                        end
                    end
                end
            end
        end
    end
endmodule

// File: rtl/freq_repl_chk.sv
module freq_repl_chk #(
    parameter int NUM_WAYS = 3,
    parameter int CNT_W    = 4,
    parameter int RANK_W   = 2
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       req_valid,
    input logic                       rsp_valid,
    input logic                       rsp_hit,
    input logic                       evict_valid,
    input logic [NUM_WAYS-1:0]        vld_vec,
    input logic [NUM_WAYS*CNT_W-1:0]  cnt_flat,
    input logic [NUM_WAYS*RANK_W-1:0] rank_flat
);
    logic perm_ok;
    logic cnt_ok;

    always_comb begin
        logic [NUM_WAYS-1:0] seen;
        seen    = '0;
        perm_ok = 1'b1;
        for (int w = 0; w < NUM_WAYS; w++) begin
            if (int'(rank_flat[w*RANK_W +: RANK_W]) >= NUM_WAYS) perm_ok = 1'b0;
            else seen[rank_flat[w*RANK_W +: RANK_W]] = 1'b1;
        end
        if ($countones(seen) != NUM_WAYS) perm_ok = 1'b0;
    end

    always_comb begin
        cnt_ok = 1'b1;
        for (int w = 0; w < NUM_WAYS; w++)
            if (vld_vec[w] && cnt_flat[w*CNT_W +: CNT_W] == '0) cnt_ok = 1'b0;
    end

    // R9
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    // R9
    rsp_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    // R7
    evict_on_miss_chk: assert property (@(posedge clk) disable iff (rst)
        evict_valid |-> (rsp_valid && !rsp_hit));

    // R2
    evict_only_full_chk: assert property (@(posedge clk) disable iff (rst)
        evict_valid |-> $past(&vld_vec));

    // R8
    rank_perm_chk: assert property (@(posedge clk) disable iff (rst)
        perm_ok);

    // R3
    cnt_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_ok);

    // R9
    idle_state_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> ($stable(vld_vec) && $stable(cnt_flat) && $stable(rank_flat)));
endmodule

bind freq_repl_unit freq_repl_chk #(
    .NUM_WAYS(NUM_WAYS), .CNT_W(CNT_W), .RANK_W(RANK_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .rsp_valid  (rsp_valid),
    .rsp_hit    (rsp_hit),
    .evict_valid(evict_valid),
    .vld_vec    (vld_vec),
    .cnt_flat   (cnt_flat),
    .rank_flat  (rank_flat)
);

// File: tb/freq_repl_unit_tb.sv
module freq_repl_unit_tb;
    localparam int CLK_PERIOD = 10;
    localparam int TAG_W = 8;
    localparam int WAY_W = 2;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             req_valid = 1'b0;
    logic [TAG_W-1:0] req_tag = '0;
    logic             rsp_valid;
    logic             rsp_hit;
    logic [WAY_W-1:0] rsp_way;
    logic             evict_valid;
    logic [TAG_W-1:0] evict_tag;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    typedef struct {
        logic [TAG_W-1:0] tag;
        logic             hit;
        int               way;
        logic             ev;
        logic [TAG_W-1:0] etag;
        string            rq;
    } exp_t;

    exp_t sb[$];

    freq_repl_unit u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_tag(req_tag),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_way(rsp_way),
        .evict_valid(evict_valid), .evict_tag(evict_tag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic acc(input logic [TAG_W-1:0] t, input logic eh, input int ew,
                       input logic ee, input logic [TAG_W-1:0] et, input string rq);
        exp_t e;
        @(negedge clk);
        req_valid = 1'b1;
        req_tag   = t;
        e.tag = t; e.hit = eh; e.way = ew; e.ev = ee; e.etag = et; e.rq = rq;
        sb.push_back(e);
    endtask

    task automatic idle_chk(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
        end
        @(negedge clk);
        n_tests++;
        if (rsp_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R9 idle rsp_valid got %0b exp 0", rsp_valid);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        req_valid = 1'b0;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        n_tests++;
        if (rsp_valid !== 1'b0 || rsp_hit !== 1'b0 || evict_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 reset outputs got v=%0b h=%0b e=%0b exp 0 0 0",
                     rsp_valid, rsp_hit, evict_valid);
        end
    endtask

    // Monitor: pops expected items as responses appear.
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && rsp_valid === 1'b1) begin
                if (sb.size() == 0) begin
                    n_tests++; n_fail++;
                    $display("FAIL R9 unexpected response got valid=1 exp none");
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    n_tests++;
                    if (rsp_hit !== e.hit || int'(rsp_way) != e.way || evict_valid !== e.ev ||
                        (e.ev && evict_tag !== e.etag)) begin
                        n_fail++;
                        $display("FAIL %s tag=%0d got hit=%0b way=%0d ev=%0b etag=%0d exp hit=%0b way=%0d ev=%0b etag=%0d",
                                 e.rq, e.tag, rsp_hit, rsp_way, evict_valid, evict_tag,
                                 e.hit, e.way, e.ev, e.etag);
                    end
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired got running exp finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        do_reset();

        // R10 frequency pattern 1,1,2,2,3,4,3,4; R2 fills, R4 hits, R5 low-count victim
        acc(1, 0, 0, 0, 0, "R2");
        acc(1, 1, 0, 0, 0, "R4");
        acc(2, 0, 1, 0, 0, "R2");
        acc(2, 1, 1, 0, 0, "R4");
        acc(3, 0, 2, 0, 0, "R2");
        acc(4, 0, 2, 1, 3, "R5");
        acc(3, 0, 2, 1, 4, "R10");
        acc(4, 0, 2, 1, 3, "R10");
        idle_chk(2);
        acc(1, 1, 0, 0, 0, "R9");
        idle_chk(1);

        // R10 cyclic sweep misses everywhere; R6 LRU tie-break; R1 first miss after reset
        do_reset();
        acc(1, 0, 0, 0, 0, "R1");
        acc(2, 0, 1, 0, 0, "R2");
        acc(3, 0, 2, 0, 0, "R2");
        acc(4, 0, 0, 1, 1, "R6");
        acc(1, 0, 1, 1, 2, "R10");
        acc(2, 0, 2, 1, 3, "R10");
        acc(3, 0, 0, 1, 4, "R10");
        idle_chk(1);

        // R7 evicted tag returns with no history
        do_reset();
        acc(1, 0, 0, 0, 0, "R2");
        acc(2, 0, 1, 0, 0, "R2");
        acc(3, 0, 2, 0, 0, "R2");
        acc(1, 1, 0, 0, 0, "R4");
        acc(2, 1, 1, 0, 0, "R4");
        acc(3, 1, 2, 0, 0, "R4");
        acc(4, 0, 0, 1, 1, "R6");
        acc(1, 0, 0, 1, 4, "R5");
        acc(5, 0, 0, 1, 1, "R7");
        idle_chk(1);

        // R3 saturation: 15 hits would wrap a 4-bit counter to 0
        do_reset();
        acc(10, 0, 0, 0, 0, "R2");
        for (int i = 0; i < 15; i++) acc(10, 1, 0, 0, 0, "R3");
        acc(11, 0, 1, 0, 0, "R2");
        acc(12, 0, 2, 0, 0, "R2");
        acc(11, 1, 1, 0, 0, "R4");
        acc(12, 1, 2, 0, 0, "R4");
        acc(13, 0, 1, 1, 11, "R3");
        idle_chk(1);

        // R8 recency follows access order, not way index
        do_reset();
        acc(1, 0, 0, 0, 0, "R2");
        acc(2, 0, 1, 0, 0, "R2");
        acc(3, 0, 2, 0, 0, "R2");
        acc(3, 1, 2, 0, 0, "R4");
        acc(1, 1, 0, 0, 0, "R4");
        acc(2, 1, 1, 0, 0, "R4");
        acc(2, 1, 1, 0, 0, "R3");
        acc(4, 0, 2, 1, 3, "R8");
        idle_chk(2);

        n_tests++;
        if (sb.size() != 0) begin
            n_fail++;
            $display("FAIL R9 responses missing got %0d pending exp 0", sb.size());
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule